// File: doc/BRIEF.md
# Trap Handler Target and Exception PC Unit

This unit holds three trap-related control registers: the handler vector register (a word-aligned base plus a two-bit dispatch mode), the trap cause register (an interrupt flag plus a cause code) and the exception program counter. From the stored vector and cause it continuously produces the address of the trap handler. It also returns the exception PC for reads, with the low bits legalized to match whether compressed (16-bit) instructions are in use.

Each register is loaded by its own write strobe and data bus, and the new value is visible one clock edge later. Two inputs describe compressed-instruction support: whether it is enabled now, and whether it could be enabled by software. Trap entry sequencing, privilege switching and any other control registers belong to neighbouring logic.

Top module: `trap_vec_unit`

## Requirements
- R1: After reset the vector base, cause and exception PC are all zero and the mode is direct, so `trapTarget` reads 0, `trapTargetValid` reads 1 and `epcRead` reads 0.
- R2: Bits 1:0 of a vector write select the mode (0 = direct, 1 = vectored) and bits XLEN-1:2 the base. A write with mode 0 or 1 loads both.
- R3: A vector write whose bits 1:0 are 2 or 3 (reserved) loads the base but keeps the previously stored mode.
- R4: In direct mode `trapTarget` equals the stored base with bits 1:0 zero, whatever the cause.
- R5: In vectored mode, when cause bit XLEN-1 is 1 (interrupt), `trapTarget` equals the base plus four times the cause code (bits XLEN-2:0).
- R6: In vectored mode, when cause bit XLEN-1 is 0 (exception), `trapTarget` equals the base.
- R7: `trapTargetValid` is 1 whenever the stored mode is direct or vectored. Because reserved modes are never stored, it stays 1 after reserved-mode writes.
- R8: An exception PC write always stores bit 0 as zero.
- R9: An exception PC write stores bit 1 as zero when compressed support is neither enabled (`cEnabled`) nor enableable (`cWritable`). Otherwise bit 1 is stored as written.
- R10: `epcRead` shows bit 1 as zero while `cEnabled` is 0, and shows the stored bit 1 once `cEnabled` is 1.
- R11: A write takes effect at the next rising clock edge. Registers whose write enable is low hold their value, whatever their data bus carries.
- R12: The vectored-mode addition wraps modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tvecWrEn | input | 1 | Vector register write strobe |
| tvecWrData | input | XLEN | Vector write data: base in XLEN-1:2, mode in 1:0 |
| causeWrEn | input | 1 | Cause register write strobe |
| causeWrData | input | XLEN | Cause write data: interrupt flag in XLEN-1, code below |
| epcWrEn | input | 1 | Exception PC write strobe |
| epcWrData | input | XLEN | Exception PC write data |
| cEnabled | input | 1 | Compressed instructions currently enabled |
| cWritable | input | 1 | Compressed support can be enabled by software |
| trapTarget | output | XLEN | Handler address |
| trapTargetValid | output | 1 | Handler address is meaningful |
| epcRead | output | XLEN | Legalized exception PC read value |

## Verification
The bench writes reserved mode codes from both direct and vectored states. A design that loads the mode blindly ends up in a reserved state and drops the valid flag, and one that discards the whole write leaves the old base in the target. Vectored mode is exercised with both interrupt and exception causes, and with a base near the top of the address space. A design that offsets exceptions, or that mishandles the carry, gives a wrong handler address. The exception PC is written under all three combinations of enabled and enableable compressed support, then read back as `cEnabled` toggles. This exposes a design that clears bit 1 too eagerly, never clears it, or masks at write time in place of read time.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;

  // Dispatch mode held in the low two bits of the vector register
  typedef enum logic [1:0] {
    TV_DIRECT   = 2'd0,
    TV_VECTORED = 2'd1,
    TV_RSVD2    = 2'd2,
    TV_RSVD3    = 2'd3
  } tvModeE;

  // Strobes from control to datapath
  typedef struct packed {
    logic baseLoad;
    logic modeLoad;
    logic causeLoad;
    logic epcLoad;
    logic epcKeepBit1;
  } strobeS;

endpackage

// File: rtl/trap_vec_ctrl.sv
module trap_vec_ctrl
  import trap_vec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tvecWrEn,
  input  logic [1:0] tvecWrMode,
  input  logic       causeWrEn,
  input  logic       epcWrEn,
  input  logic       cEnabled,
  input  logic       cWritable,
  output strobeS     strobes
);

  logic modeLegal;

  always_comb begin
    modeLegal = (tvModeE'(tvecWrMode) == TV_DIRECT) ||
                (tvModeE'(tvecWrMode) == TV_VECTORED);
    strobes.baseLoad    = tvecWrEn;
    strobes.modeLoad    = tvecWrEn && modeLegal;
    strobes.causeLoad   = causeWrEn;
    strobes.epcLoad     = epcWrEn;
    strobes.epcKeepBit1 = cEnabled || cWritable;
  end

  // R3
  rsvd_mode_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tvecWrEn && tvecWrMode[1]) |-> !strobes.modeLoad);

  // R2
  legal_mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tvecWrEn && !tvecWrMode[1]) |-> (strobes.modeLoad && strobes.baseLoad));

endmodule

// File: rtl/trap_vec_dp.sv
module trap_vec_dp
  import trap_vec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeS          strobes,
  input  logic [XLEN-1:0] tvecWrData,
  input  logic [XLEN-1:0] causeWrData,
  input  logic [XLEN-1:0] epcWrData,
  input  logic            cEnabled,
  output logic [XLEN-1:0] trapTarget,
  output logic            trapTargetValid,
  output logic [XLEN-1:0] epcRead
);

  localparam int BASEW = XLEN - 2;
  localparam int CODEW = XLEN - 1;

  logic [BASEW-1:0] baseReg;
  tvModeE           modeReg;
  logic [XLEN-1:0]  causeReg;
  logic [XLEN-1:0]  epcReg;

  logic [XLEN-1:0]  baseAddr;
  logic [XLEN-1:0]  vecOffset;
  logic [XLEN-1:0]  epcWrMask;
  logic [XLEN-1:0]  epcRdMask;
  logic             isIntr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      modeReg  <= TV_DIRECT;
      causeReg <= '0;
      epcReg   <= '0;
    end else begin
      if (strobes.baseLoad)  baseReg  <= tvecWrData[XLEN-1:2];
      if (strobes.modeLoad)  modeReg  <= tvModeE'(tvecWrData[1:0]);
      if (strobes.causeLoad) causeReg <= causeWrData;
      if (strobes.epcLoad)   epcReg   <= epcWrData & epcWrMask;
    end
  end

  always_comb begin
    epcWrMask = strobes.epcKeepBit1 ? ~XLEN'(1) : ~XLEN'(3);
    epcRdMask = cEnabled ? '1 : ~XLEN'(2);
    epcRead   = epcReg & epcRdMask;
  end

  always_comb begin
    isIntr    = causeReg[XLEN-1];
    baseAddr  = {baseReg, 2'b00};
    vecOffset = {1'b0, causeReg[CODEW-1:0]} << 2;
    trapTargetValid = 1'b1;
    unique case (modeReg)
      TV_DIRECT:   trapTarget = baseAddr;
      TV_VECTORED: trapTarget = isIntr ? baseAddr + vecOffset : baseAddr;
      default: begin
        trapTarget      = '0;
        trapTargetValid = 1'b0;
      end
    endcase
  end

  // R3
  mode_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.baseLoad && !strobes.modeLoad) |=> $stable(modeReg));

  // R7
  target_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTargetValid);

  // R4
  direct_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == TV_DIRECT) |-> (trapTarget[1:0] == 2'b00));

  // R8
  epc_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    epcRead[0] == 1'b0);

  // R10
  epc_rd_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cEnabled |-> (epcRead[1] == 1'b0));

endmodule

// File: rtl/trap_vec_unit.sv
module trap_vec_unit
  import trap_vec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tvecWrEn,
  input  logic [XLEN-1:0] tvecWrData,
  input  logic            causeWrEn,
  input  logic [XLEN-1:0] causeWrData,
  input  logic            epcWrEn,
  input  logic [XLEN-1:0] epcWrData,
  input  logic            cEnabled,
  input  logic            cWritable,
  output logic [XLEN-1:0] trapTarget,
  output logic            trapTargetValid,
  output logic [XLEN-1:0] epcRead
);

  strobeS strobes;

  trap_vec_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tvecWrEn   (tvecWrEn),
    .tvecWrMode (tvecWrData[1:0]),
    .causeWrEn  (causeWrEn),
    .epcWrEn    (epcWrEn),
    .cEnabled   (cEnabled),
    .cWritable  (cWritable),
    .strobes    (strobes)
  );

  trap_vec_dp #(.XLEN(XLEN)) i_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .tvecWrData      (tvecWrData),
    .causeWrData     (causeWrData),
    .epcWrData       (epcWrData),
    .cEnabled        (cEnabled),
    .trapTarget      (trapTarget),
    .trapTargetValid (trapTargetValid),
    .epcRead         (epcRead)
  );

endmodule

// File: tb/test_trap_vec_unit.sv
`timescale 1ns/1ps
module test_trap_vec_unit;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            tvecWrEn = 1'b0;
  logic [XLEN-1:0] tvecWrData = '0;
  logic            causeWrEn = 1'b0;
  logic [XLEN-1:0] causeWrData = '0;
  logic            epcWrEn = 1'b0;
  logic [XLEN-1:0] epcWrData = '0;
  logic            cEnabled = 1'b1;
  logic            cWritable = 1'b0;
  logic [XLEN-1:0] trapTarget;
  logic            trapTargetValid;
  logic [XLEN-1:0] epcRead;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trap_vec_unit #(.XLEN(XLEN)) i_trap_vec_unit (
    .clk(clk), .rstN(rstN),
    .tvecWrEn(tvecWrEn), .tvecWrData(tvecWrData),
    .causeWrEn(causeWrEn), .causeWrData(causeWrData),
    .epcWrEn(epcWrEn), .epcWrData(epcWrData),
    .cEnabled(cEnabled), .cWritable(cWritable),
    .trapTarget(trapTarget), .trapTargetValid(trapTargetValid),
    .epcRead(epcRead)
  );

  task automatic check(string req, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive each write at a falling edge, release it at the next falling edge
  task automatic wrTvec(logic [XLEN-1:0] d);
    @(negedge clk); tvecWrEn = 1'b1; tvecWrData = d;
    @(negedge clk); tvecWrEn = 1'b0;
  endtask

  task automatic wrCause(logic [XLEN-1:0] d);
    @(negedge clk); causeWrEn = 1'b1; causeWrData = d;
    @(negedge clk); causeWrEn = 1'b0;
  endtask

  task automatic wrEpc(logic [XLEN-1:0] d);
    @(negedge clk); epcWrEn = 1'b1; epcWrData = d;
    @(negedge clk); epcWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 target", trapTarget, '0);
    check("R1 valid", XLEN'(trapTargetValid), XLEN'(1));
    check("R1 epc", epcRead, '0);
  endtask

  task automatic testDirect();
    wrTvec(32'h1000_0100);
    wrCause(32'h8000_0005);
    check("R4 direct intr", trapTarget, 32'h1000_0100);
    wrCause(32'h0000_0002);
    check("R4 direct exc", trapTarget, 32'h1000_0100);
  endtask

  task automatic testVectored();
    wrTvec(32'h2000_0001);
    wrCause(32'h8000_0007);
    check("R2/R5 vectored intr", trapTarget, 32'h2000_001C);
    wrCause(32'h0000_0003);
    check("R6 vectored exc", trapTarget, 32'h2000_0000);
  endtask

  task automatic testReserved();
    wrCause(32'h8000_0007);
    wrTvec(32'h3000_0402);
    check("R3 base loads, vectored kept", trapTarget, 32'h3000_041C);
    check("R7 valid after rsvd", XLEN'(trapTargetValid), XLEN'(1));
    wrTvec(32'h4000_0000);
    wrTvec(32'h5000_0003);
    check("R3 base loads, direct kept", trapTarget, 32'h5000_0000);
    check("R7 valid after rsvd 3", XLEN'(trapTargetValid), XLEN'(1));
  endtask

  task automatic testWrap();
    wrTvec(32'hFFFF_FFF1);
    wrCause(32'h8000_0005);
    check("R12 wrap", trapTarget, 32'h0000_0004);
  endtask

  task automatic testEpc();
    cEnabled = 1'b1; cWritable = 1'b0;
    wrEpc(32'h1234_5677);
    check("R8 bit0 cleared", epcRead, 32'h1234_5676);
    cEnabled = 1'b0; cWritable = 1'b0;
    wrEpc(32'h0000_00FF);
    check("R9 bit1 cleared", epcRead, 32'h0000_00FC);
    cEnabled = 1'b1;
    #1;
    check("R9 bit1 stored zero", epcRead, 32'h0000_00FC);
    cEnabled = 1'b0; cWritable = 1'b1;
    wrEpc(32'h0000_00AB);
    check("R10 read masked", epcRead, 32'h0000_00A8);
    cEnabled = 1'b1;
    #1;
    check("R10 stored bit1 visible", epcRead, 32'h0000_00AA);
  endtask

  task automatic testHold();
    // vectored, interrupt cause 3 -> base + 12
    wrTvec(32'h6000_0001);
    wrCause(32'h8000_0003);
    check("R11 setup", trapTarget, 32'h6000_000C);
    @(negedge clk);
    tvecWrData = 32'h7777_7770; causeWrData = 32'h0; epcWrData = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    check("R11 target held", trapTarget, 32'h6000_000C);
    check("R11 epc held", epcRead, 32'h0000_00AA);
    // write becomes visible only after the edge
    tvecWrEn = 1'b1; tvecWrData = 32'h7000_0000;
    #1;
    check("R11 not before edge", trapTarget, 32'h6000_000C);
    @(negedge clk); tvecWrEn = 1'b0;
    check("R11 after edge", trapTarget, 32'h7000_0000);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testVectored();
    testReserved();
    testWrap();
    testEpc();
    testHold();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule